// File: doc/BRIEF.md
# Tournament Conditional Branch Predictor

This block predicts whether a conditional branch will be taken. Two component predictors each give an opinion. The local predictor keeps a short history of outcomes for each branch, selected by the fetch PC, and uses that pattern to pick a 2-bit counter. The global predictor uses a shift register of recent branch outcomes across the whole program to pick its own counter. A third table of 2-bit counters, indexed by the same global history, decides which opinion becomes the final answer. The answer is combinational and is produced in the same cycle that the fetch PC is presented.

Prediction is speculative. When the front end marks a lookup as a real branch, the predicted direction is shifted into the global history at once. The global history used for the lookup is also returned so that it can travel with the branch. When the branch resolves, the pipeline sends back the PC, the real outcome, a misprediction flag and that history snapshot. The block then trains the counters and shifts the outcome into the branch's local history. On a misprediction it rebuilds the global history from the snapshot plus the real outcome.

Top module: `tourn_bp`

## Requirements
- R1: While reset is held low, and after it is released with no other activity, `pred_taken` is 0 and `pred_ghist` is all zeros. All counters start at 01, and all local and global histories start at zero.
- R2: `pred_taken` is combinational in the same cycle. It equals the global component's prediction when the MSB of the chooser counter indexed by the current global history is 1. Otherwise it equals the local component's prediction.
- R3: The local component selects a local history entry with PC bits [2 +: LIDX_W]. That history pattern then indexes the local counter table, and the counter's MSB is the local prediction.
- R4: The global component's prediction is the MSB of the global counter indexed by the current global history.
- R5: On an update, the local counter and the global counter both move toward the outcome: +1 if taken, -1 if not taken. They saturate at 0 and 3.
- R6: On an update, the outcome is shifted in at bit 0 of that branch's local history entry, and the oldest bit is dropped.
- R7: When `pred_valid` is 1 and no mispredicted update arrives in the same cycle, the global history shifts left by one on the next edge, with `pred_taken` entering at bit 0.
- R8: When `upd_valid` and `upd_mispred` are both 1, the global history on the next edge becomes {`upd_ghist`[GH_W-2:0], `upd_taken`}. This overrides any speculative shift in the same cycle.
- R9: On an update, the global counter and the chooser counter are both indexed by `upd_ghist`. The chooser counter changes only when the local and global predictions for that update disagree. It moves +1 toward global when global was right, and -1 when local was right.
- R10: `pred_ghist` always shows the current global history register, which is the snapshot the lookup used.
- R11: With `upd_valid` low, no table or local history changes. With both `upd_valid` and `pred_valid` low, the global history holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid | input | 1 | The lookup is a real branch; shift its prediction into the global history |
| pred_pc | input | PC_W | Fetch PC of the branch being predicted |
| pred_taken | output | 1 | Final direction prediction |
| pred_ghist | output | GH_W | Global history used for this lookup (snapshot) |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_mispred | input | 1 | The resolved branch was mispredicted |
| upd_ghist | input | GH_W | History snapshot captured when the branch was predicted |

## Verification
A wrong value in any counter, history entry or the global history register only becomes visible when a later lookup selects that entry. Once selected, the error shows in `pred_taken` in that same cycle. A wrong global history shows in `pred_ghist` right after the edge that produced it. The bench uses a small configuration, so every table entry is revisited within a few dozen cycles. It follows a cycle-accurate model through saturating, periodic, history-correlated and pseudo-random outcome streams, with mispredictions mixed in. Any divergence is therefore caught within a few lookups of the faulty write.

// File: rtl/tbp_pkg.sv
// Shared types and helpers for the tournament branch predictor.
// Assumes every counter in the block is 2 bits wide.
package tbp_pkg;
    typedef logic [1:0] ctr2_t;

    // Reset value of every counter (weakly not-taken / weakly local)
    localparam ctr2_t CTR_WEAK_LOW = 2'b01;

    // Saturating step of a 2-bit counter toward 'up'
    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        ctr2_t r;
        if (up) r = (c == 2'b11) ? c : c + 2'b01;
        else    r = (c == 2'b00) ? c : c - 2'b01;
        return r;
    endfunction
endpackage

// File: rtl/tbp_local.sv
// Local component: per-branch history table plus pattern-indexed counters.
// Assumes the caller has already extracted the table index from the PC.
// One lookup port and one training port; training uses the history
// currently stored for the branch.
module tbp_local
    import tbp_pkg::*;
#(
    parameter int LIDX_W = 10,
    parameter int LH_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LIDX_W-1:0] rd_idx,
    output logic              rd_pred,
    input  logic              wr_en,
    input  logic [LIDX_W-1:0] wr_idx,
    input  logic              wr_taken,
    output logic              wr_pred
);
    localparam int HIST_N = 1 << LIDX_W;
    localparam int CTR_N  = 1 << LH_W;

    logic [LH_W-1:0] hist_tbl [HIST_N];
    ctr2_t           ctr_tbl  [CTR_N];
    logic [LH_W-1:0] wr_hist;

    // Look up the prediction for the fetch branch and for the resolving branch
    always_comb begin
        rd_pred = ctr_tbl[hist_tbl[rd_idx]][1];
        wr_hist = hist_tbl[wr_idx];
        wr_pred = ctr_tbl[wr_hist][1];
    end

    // Shift the resolved outcome into the branch's own history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST_N; i++) hist_tbl[i] <= '0;
        end else if (wr_en) begin
            hist_tbl[wr_idx] <= {wr_hist[LH_W-2:0], wr_taken};
        end
    end

    // Train the pattern counter selected by the stored history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < CTR_N; j++) ctr_tbl[j] <= CTR_WEAK_LOW;
        end else if (wr_en) begin
            ctr_tbl[wr_hist] <= ctr_step(ctr_tbl[wr_hist], wr_taken);
        end
    end

    // R5: a taken update on a saturated-high counter leaves it at 3
    a_r5_local_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && ctr_tbl[wr_hist] == 2'b11
        |=> ctr_tbl[$past(wr_hist)] == 2'b11);

    // R6: the newest bit of the trained history is the outcome
    a_r6_local_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist_tbl[$past(wr_idx)][0] == $past(wr_taken));
endmodule

// File: rtl/tbp_global.sv
// Global component: the global history register plus its counter table.
// Assumes the update snapshot is the history that the lookup saw.
// A mispredicted update repairs the history; otherwise a valid lookup
// shifts in its own prediction.
module tbp_global
    import tbp_pkg::*;
#(
    parameter int GH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spec_en,
    input  logic            spec_dir,
    output logic [GH_W-1:0] ghr,
    output logic            rd_pred,
    input  logic            wr_en,
    input  logic            wr_taken,
    input  logic            wr_mispred,
    input  logic [GH_W-1:0] wr_snap,
    output logic            wr_pred
);
    localparam int CTR_N = 1 << GH_W;

    ctr2_t ctr_tbl [CTR_N];
    logic  repair;

    // Read the counters for the lookup and for the resolving branch
    always_comb begin
        rd_pred = ctr_tbl[ghr][1];
        wr_pred = ctr_tbl[wr_snap][1];
        repair  = wr_en && wr_mispred;
    end

    // Update the global history: repair first, then speculative shift
    always_ff @(posedge clk) begin
        if (!rst_n)        ghr <= '0;
        else if (repair)   ghr <= {wr_snap[GH_W-2:0], wr_taken};
        else if (spec_en)  ghr <= {ghr[GH_W-2:0], spec_dir};
    end

    // Train the counter selected by the snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CTR_N; i++) ctr_tbl[i] <= CTR_WEAK_LOW;
        end else if (wr_en) begin
            ctr_tbl[wr_snap] <= ctr_step(ctr_tbl[wr_snap], wr_taken);
        end
    end

    // R8: a repair rebuilds the history from the snapshot and the outcome
    a_r8_ghr_repair: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_mispred
        |=> ghr == {$past(wr_snap[GH_W-2:0]), $past(wr_taken)});

    // R7: a lookup without repair pushes its prediction in at bit 0
    a_r7_ghr_spec: assert property (@(posedge clk) disable iff (!rst_n)
        spec_en && !(wr_en && wr_mispred)
        |=> ghr[0] == $past(spec_dir) && ghr[GH_W-1:1] == $past(ghr[GH_W-2:0]));

    // R11: with neither lookup nor update the history is held
    a_r11_ghr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_en && !wr_en |=> $stable(ghr));

    // R5: a not-taken update on a saturated-low counter leaves it at 0
    a_r5_global_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && ctr_tbl[wr_snap] == 2'b00
        |=> ctr_tbl[$past(wr_snap)] == 2'b00);
endmodule

// File: rtl/tbp_chooser.sv
// Chooser: counters indexed by global history that say which component
// to trust (MSB set selects the global component).
// Assumes the component predictions given for training are those that
// the current tables hold for the resolving branch.
module tbp_chooser
    import tbp_pkg::*;
#(
    parameter int GH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [GH_W-1:0] rd_idx,
    output logic            use_global,
    input  logic            wr_en,
    input  logic [GH_W-1:0] wr_idx,
    input  logic            wr_local,
    input  logic            wr_global,
    input  logic            wr_taken
);
    localparam int CTR_N = 1 << GH_W;

    ctr2_t sel_tbl [CTR_N];
    logic  disagree;

    // Select the component and detect a training opportunity
    always_comb begin
        use_global = sel_tbl[rd_idx][1];
        disagree   = wr_local != wr_global;
    end

    // Move toward whichever component got the outcome right
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CTR_N; i++) sel_tbl[i] <= CTR_WEAK_LOW;
        end else if (wr_en && disagree) begin
            sel_tbl[wr_idx] <= ctr_step(sel_tbl[wr_idx], wr_global == wr_taken);
        end
    end

    // R9: when both components agree the chooser entry is left alone
    a_r9_chooser_agree_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !disagree |=> sel_tbl[$past(wr_idx)] == $past(sel_tbl[wr_idx]));

    // R9: when global alone was right the entry does not decrease
    a_r9_chooser_toward_global: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && disagree && wr_global == wr_taken
        |=> sel_tbl[$past(wr_idx)] >= $past(sel_tbl[wr_idx]));
endmodule

// File: rtl/tourn_bp.sv
// Tournament conditional branch predictor top level.
// Combines the local and global components through the chooser. The
// answer is combinational from the fetch PC. Assumes instructions are
// 4-byte aligned, so PC bits [1:0] carry no information.
module tourn_bp
    import tbp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int LIDX_W = 10,
    parameter int LH_W   = 10,
    parameter int GH_W   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pred_valid,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic [GH_W-1:0] pred_ghist,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_mispred,
    input  logic [GH_W-1:0] upd_ghist
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + LIDX_W;

    logic [LIDX_W-1:0] rd_idx, wr_idx;
    logic [GH_W-1:0]   ghr;
    logic              loc_rd, glb_rd, use_glb;
    logic              loc_wr, glb_wr;
    logic              pc_unused;

    // Extract table indices from the PCs; collect the bits not used
    always_comb begin
        rd_idx    = pred_pc[IDX_LO +: LIDX_W];
        wr_idx    = upd_pc[IDX_LO +: LIDX_W];
        pc_unused = ^{pred_pc[PC_W-1:IDX_HI], pred_pc[IDX_LO-1:0],
                      upd_pc[PC_W-1:IDX_HI],  upd_pc[IDX_LO-1:0]};
    end

    tbp_local #(.LIDX_W(LIDX_W), .LH_W(LH_W)) u_local (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_pred  (loc_rd),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken),
        .wr_pred  (loc_wr)
    );

    tbp_global #(.GH_W(GH_W)) u_global (
        .clk        (clk),
        .rst_n      (rst_n),
        .spec_en    (pred_valid),
        .spec_dir   (pred_taken),
        .ghr        (ghr),
        .rd_pred    (glb_rd),
        .wr_en      (upd_valid),
        .wr_taken   (upd_taken),
        .wr_mispred (upd_mispred),
        .wr_snap    (upd_ghist),
        .wr_pred    (glb_wr)
    );

    tbp_chooser #(.GH_W(GH_W)) u_chooser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (ghr),
        .use_global (use_glb),
        .wr_en      (upd_valid),
        .wr_idx     (upd_ghist),
        .wr_local   (loc_wr),
        .wr_global  (glb_wr),
        .wr_taken   (upd_taken)
    );

    // Final selection and snapshot output
    always_comb begin
        pred_taken = use_glb ? glb_rd : loc_rd;
        pred_ghist = ghr;
    end

    // R10: the snapshot output follows the history across a repair edge
    a_r10_snapshot_repair: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_mispred
        |=> pred_ghist[0] == $past(upd_taken));

    // R2: if both components agree, the final answer is their common value
    a_r2_agree_out: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rd == glb_rd |-> pred_taken == loc_rd);
endmodule

// File: tb/tourn_bp_test.sv
module tourn_bp_test;
    localparam int PC_W = 8, LIDX_W = 2, LH_W = 3, GH_W = 4;
    localparam time CLK_P = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pred_valid = 1'b0, pred_taken;
    logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
    logic [GH_W-1:0] pred_ghist, upd_ghist = '0;
    logic upd_valid = 1'b0, upd_taken = 1'b0, upd_mispred = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tourn_bp #(.PC_W(PC_W), .LIDX_W(LIDX_W), .LH_W(LH_W), .GH_W(GH_W)) uut (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_ghist(pred_ghist), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_mispred(upd_mispred),
        .upd_ghist(upd_ghist));

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Reference state, computed from the requirements
    logic [LH_W-1:0] m_lht [1<<LIDX_W];
    logic [1:0]      m_lct [1<<LH_W];
    logic [1:0]      m_gct [1<<GH_W];
    logic [1:0]      m_ch  [1<<GH_W];
    logic [GH_W-1:0] m_ghr;

    // Branch waiting for resolution
    logic            pend_v = 0, pend_pred = 0;
    logic [PC_W-1:0] pend_pc = '0;
    logic [GH_W-1:0] pend_snap = '0;
    int              pat_cnt [1<<LIDX_W];
    logic [1:0]      last_out = 2'b00;
    logic [15:0]     lfsr = 16'hACE1;

    function automatic logic [1:0] msat(input logic [1:0] c, input logic up);
        if (up) return (c == 2'b11) ? c : c + 2'b01;
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < (1<<LIDX_W); i++) begin m_lht[i] = '0; pat_cnt[i] = 0; end
        for (int i = 0; i < (1<<LH_W); i++) m_lct[i] = 2'b01;
        for (int i = 0; i < (1<<GH_W); i++) begin m_gct[i] = 2'b01; m_ch[i] = 2'b01; end
        m_ghr = '0;
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic model_pred(input logic [PC_W-1:0] pc);
        logic lp, gp;
        lp = m_lct[m_lht[pc[2 +: LIDX_W]]][1];
        gp = m_gct[m_ghr][1];
        return m_ch[m_ghr][1] ? gp : lp;
    endfunction

    // Outcome of the pending branch under each stimulus mode
    function automatic logic outcome(input int mode, input logic [PC_W-1:0] pc);
        case (mode)
            0: return 1'b1;
            1: return 1'b0;
            2: return (pat_cnt[pc[2 +: LIDX_W]] % 3) != 0;
            3: return ~(last_out[0] ^ last_out[1]);
            default: return lfsr[0];
        endcase
    endfunction

    // One cycle: present a lookup and resolve the previous branch
    task automatic step(input string tag, input logic pv, input logic [PC_W-1:0] pc,
                        input logic do_upd, input int mode);
        logic t, mp, lp, gp, uv, mis;
        logic [LIDX_W-1:0] ix;
        logic [LH_W-1:0] h;
        @(negedge clk);
        uv  = do_upd && pend_v;
        t   = outcome(mode, pend_pc);
        mis = (pend_pred != t);
        pred_valid = pv; pred_pc = pc;
        upd_valid = uv; upd_pc = pend_pc; upd_taken = t;
        upd_mispred = mis; upd_ghist = pend_snap;
        #1;
        mp = model_pred(pc);
        cmp(tag, "pred_taken", int'(pred_taken), int'(mp));
        cmp("R10", "pred_ghist", int'(pred_ghist), int'(m_ghr));
        if (pv) begin pend_pc <= pc; end
        if (uv) begin
            ix = pend_pc[2 +: LIDX_W];
            h  = m_lht[ix];
            lp = m_lct[h][1];
            gp = m_gct[pend_snap][1];
            m_lct[h] = msat(m_lct[h], t);
            m_gct[pend_snap] = msat(m_gct[pend_snap], t);
            if (lp != gp) m_ch[pend_snap] = msat(m_ch[pend_snap], gp == t);
            m_lht[ix] = {h[LH_W-2:0], t};
            pat_cnt[ix]++;
            last_out = {last_out[0], t};
        end
        if (uv && mis)  m_ghr = {pend_snap[GH_W-2:0], t};
        else if (pv)    m_ghr = {m_ghr[GH_W-2:0], mp};
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (pv) begin
            pend_snap = pred_ghist; pend_pred = mp; pend_v = 1'b1;
        end else if (uv) begin
            pend_v = 1'b0;
        end
    endtask

    task automatic run(input string tag, input int n, input int mode, input int npc);
        for (int i = 0; i < n; i++)
            step(tag, 1'b1, PC_W'((lfsr[7:0] % npc) << 2), 1'b1, mode);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R1", "pred_taken in reset", int'(pred_taken), 0);
        cmp("R1", "pred_ghist in reset", int'(pred_ghist), 0);
        rst_n = 1'b1;
        // R1: idle after reset, every PC predicts not-taken
        for (int p = 0; p < 8; p++) step("R1", 1'b0, PC_W'(p << 2), 1'b0, 0);
        // R7: speculative shifts with no updates
        for (int i = 0; i < 6; i++) step("R7", 1'b1, PC_W'(i << 2), 1'b0, 0);
        // R5: saturate high then low on a single PC
        for (int i = 0; i < 12; i++) step("R5", 1'b1, 8'h04, 1'b1, 0);
        for (int i = 0; i < 12; i++) step("R5", 1'b1, 8'h04, 1'b1, 1);
        // R3 and R6: per-branch periodic patterns learned locally
        run("R3", 400, 2, 4);
        run("R6", 400, 2, 2);
        // R4: outcomes correlated with global history
        run("R4", 400, 3, 4);
        // R2, R8 and R9: pseudo-random outcomes with frequent mispredictions
        run("R2", 600, 4, 4);
        run("R8", 300, 4, 3);
        run("R9", 600, 3, 1);
        // R11: idle cycles, then the same lookups must still agree with the model
        for (int i = 0; i < 8; i++) step("R11", 1'b0, PC_W'(i << 2), 1'b0, 4);
        for (int i = 0; i < 4; i++) step("R11", 1'b0, PC_W'(i << 2), 1'b0, 4);
        run("R9", 300, 4, 4);
        finish_run();
    end
endmodule